// File: doc/BRIEF.md
# Transceiver Datapath Reset Handshake Controller

This block sequences the reset of one serial transceiver channel. User logic raises a transmit or a receive reset request, or both at once. The controller then takes that datapath down in a fixed order, one status flag per cycle. When the datapath is fully quiet it raises a reset acknowledge and holds it for as long as the request stays high. After the request is released, the controller brings the datapath back up in stages. Transmit waits for its PLL to lock, then reports ready. Receive waits for the CDR to lock to the reference clock, then for it to lock to the incoming data, and only then reports ready.

The analog front end is abstracted into three raw lock inputs: PLL lock, CDR reference lock and CDR data lock. Each bring-up stage has a cycle limit. If a lock takes longer than that limit, a sticky per-direction error flag is raised and the ready output stays low until the lock arrives. The two reset requests are asynchronous to the controller clock. The raw lock inputs are taken as already synchronous to it.

Top module: `xcvr_rst_ctrl`

## Requirements
- R1: Each reset request passes through a two-flop synchronizer. A request that rises just before clock edge N makes the matching ready output fall at edge N+2.
- R2: On a transmit reset, the flags change one cycle apart in this order: tx_ready falls, then tx_pll_locked falls, then tx_rst_ack rises.
- R3: tx_rst_ack stays high while the synchronized transmit request is high. It falls on the cycle after the synchronized request is seen low.
- R4: During transmit bring-up, tx_pll_locked rises on the edge after pll_lock_raw is seen high. tx_ready rises one cycle later, and never without tx_pll_locked.
- R5: On a receive reset, rx_ready falls first. rx_lock_ref and rx_lock_data fall together one cycle later, and rx_rst_ack rises one cycle after that.
- R6: rx_rst_ack stays high while the synchronized receive request is high. It falls on the cycle after that request is seen low.
- R7: During receive bring-up, rx_lock_ref rises on the edge after ref_lock_raw is high. rx_lock_data rises on the edge after data_lock_raw is high, and only while rx_lock_ref is high. rx_ready rises one cycle after rx_lock_data.
- R8: The transmit and receive sequences are independent. When both requests change together, each sequence keeps the same timing it has when run alone, and a request on one direction leaves the other direction's outputs unchanged.
- R9: A request released before its acknowledge rises still completes the full shutdown. The acknowledge is then high for exactly one cycle, and bring-up follows.
- R10: When a bring-up stage sees its raw lock low for more than LOCK_TIMEOUT consecutive cycles, the matching timeout error flag is set. It stays set, even after the lock arrives, until rst. The matching ready output stays low until the lock arrives.
- R11: When data_lock_raw falls while the receive side is up, rx_ready and rx_lock_data fall on the next edge and rx_lock_ref stays high. When the data lock returns, bring-up resumes without a new request.
- R12: While rst is high, every output is low. After rst is released, both directions begin bring-up at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_rst_req | input | 1 | Asynchronous transmit reset request |
| rx_rst_req | input | 1 | Asynchronous receive reset request |
| pll_lock_raw | input | 1 | Raw transmit PLL lock from the front end |
| ref_lock_raw | input | 1 | Raw CDR lock-to-reference from the front end |
| data_lock_raw | input | 1 | Raw CDR lock-to-data from the front end |
| tx_ready | output | 1 | Transmit datapath operational |
| tx_pll_locked | output | 1 | Transmit PLL locked status |
| tx_rst_ack | output | 1 | Transmit datapath fully in reset |
| rx_ready | output | 1 | Receive datapath operational |
| rx_lock_ref | output | 1 | CDR locked to reference status |
| rx_lock_data | output | 1 | CDR locked to data status |
| rx_rst_ack | output | 1 | Receive datapath fully in reset |
| tx_timeout_err | output | 1 | Sticky transmit lock timeout |
| rx_timeout_err | output | 1 | Sticky receive lock timeout |

## Verification
Some rules hold on every cycle, and the assertions check those. An acknowledge always comes with its flags quiet, and ready never shows without its locks. Each step-down is preceded by the step before it. Acknowledges track the synchronized request, and error flags never clear. The exact cycle counts need the bench's directed scenarios: synchronizer latency, the spacing of the shutdown and bring-up flags, and the single-cycle acknowledge after an early release. The same applies to the timeout threshold, to recovery after data lock loss, and to the two directions not disturbing each other.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

    typedef enum logic [2:0] {
        TX_PLL_WAIT,
        TX_PLL_OK,
        TX_RUN,
        TX_STOP_RDY,
        TX_STOP_PLL,
        TX_HELD
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_REF_WAIT,
        RX_DATA_WAIT,
        RX_DATA_OK,
        RX_RUN,
        RX_STOP_RDY,
        RX_STOP_CDR,
        RX_HELD
    } rx_state_e;

    typedef struct packed {
        logic ready;
        logic pll_locked;
        logic ack;
    } tx_flags_t;

    typedef struct packed {
        logic ready;
        logic lock_ref;
        logic lock_data;
        logic ack;
    } rx_flags_t;

    function automatic tx_flags_t tx_decode(tx_state_e s);
        tx_flags_t f;
        f.ready      = (s == TX_RUN);
        f.pll_locked = (s == TX_PLL_OK) || (s == TX_RUN) || (s == TX_STOP_RDY);
        f.ack        = (s == TX_HELD);
        return f;
    endfunction

    function automatic rx_flags_t rx_decode(rx_state_e s);
        rx_flags_t f;
        f.ready     = (s == RX_RUN);
        f.lock_ref  = (s == RX_DATA_WAIT) || (s == RX_DATA_OK) ||
                      (s == RX_RUN) || (s == RX_STOP_RDY);
        f.lock_data = (s == RX_DATA_OK) || (s == RX_RUN) || (s == RX_STOP_RDY);
        f.ack       = (s == RX_HELD);
        return f;
    endfunction

endpackage

// File: rtl/xrc_sync.sv
module xrc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xrc_lock_timer.sv
module xrc_lock_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;
    logic         err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            err_q <= 1'b0;
        end else begin
            if (!count_en)                 cnt <= '0;
            else if (cnt != W'(LIMIT))     cnt <= cnt + 1'b1;
            if (count_en && cnt == W'(LIMIT)) err_q <= 1'b1;
        end
    end

    assign expired = err_q;
endmodule

// File: rtl/xrc_tx_seq.sv
module xrc_tx_seq
    import xrc_pkg::*;
#(
    parameter int LOCK_TIMEOUT = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      pll_lock,
    output tx_flags_t flags,
    output logic      timeout_err
);
    tx_state_e st, nxt;

    always_comb begin
        nxt = st;
        case (st)
            TX_PLL_WAIT: if (req) nxt = TX_STOP_PLL;
                         else if (pll_lock) nxt = TX_PLL_OK;
            TX_PLL_OK:   nxt = req ? TX_STOP_PLL : TX_RUN;
            TX_RUN:      if (req) nxt = TX_STOP_RDY;
            TX_STOP_RDY: nxt = TX_STOP_PLL;
            TX_STOP_PLL: nxt = TX_HELD;
            TX_HELD:     if (!req) nxt = TX_PLL_WAIT;
            default:     nxt = TX_PLL_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= TX_PLL_WAIT;
        else     st <= nxt;
    end

    assign flags = tx_decode(st);

    xrc_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .count_en ((st == TX_PLL_WAIT) && !pll_lock && !req),
        .expired  (timeout_err)
    );
endmodule

// File: rtl/xrc_rx_seq.sv
module xrc_rx_seq
    import xrc_pkg::*;
#(
    parameter int LOCK_TIMEOUT = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      ref_lock,
    input  logic      data_lock,
    output rx_flags_t flags,
    output logic      timeout_err
);
    rx_state_e st, nxt;
    logic      waiting;

    always_comb begin
        nxt = st;
        case (st)
            RX_REF_WAIT:  if (req) nxt = RX_STOP_CDR;
                          else if (ref_lock) nxt = RX_DATA_WAIT;
            RX_DATA_WAIT: if (req) nxt = RX_STOP_CDR;
                          else if (data_lock) nxt = RX_DATA_OK;
            RX_DATA_OK:   if (req) nxt = RX_STOP_CDR;
                          else if (!data_lock) nxt = RX_DATA_WAIT;
                          else nxt = RX_RUN;
            RX_RUN:       if (req) nxt = RX_STOP_RDY;
                          else if (!data_lock) nxt = RX_DATA_WAIT;
            RX_STOP_RDY:  nxt = RX_STOP_CDR;
            RX_STOP_CDR:  nxt = RX_HELD;
            RX_HELD:      if (!req) nxt = RX_REF_WAIT;
            default:      nxt = RX_REF_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= RX_REF_WAIT;
        else     st <= nxt;
    end

    assign flags   = rx_decode(st);
    assign waiting = !req && (((st == RX_REF_WAIT) && !ref_lock) ||
                              ((st == RX_DATA_WAIT) && !data_lock));

    xrc_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .count_en (waiting),
        .expired  (timeout_err)
    );
endmodule

// File: rtl/xcvr_rst_ctrl.sv
module xcvr_rst_ctrl
    import xrc_pkg::*;
#(
    parameter int LOCK_TIMEOUT = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_rst_req,
    input  logic rx_rst_req,
    input  logic pll_lock_raw,
    input  logic ref_lock_raw,
    input  logic data_lock_raw,
    output logic tx_ready,
    output logic tx_pll_locked,
    output logic tx_rst_ack,
    output logic rx_ready,
    output logic rx_lock_ref,
    output logic rx_lock_data,
    output logic rx_rst_ack,
    output logic tx_timeout_err,
    output logic rx_timeout_err
);
    logic      tx_req_s, rx_req_s;
    tx_flags_t tx_f;
    rx_flags_t rx_f;

    xrc_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
        .clk (clk), .rst (rst), .d (tx_rst_req), .q (tx_req_s)
    );
    xrc_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk (clk), .rst (rst), .d (rx_rst_req), .q (rx_req_s)
    );

    xrc_tx_seq #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .req         (tx_req_s),
        .pll_lock    (pll_lock_raw),
        .flags       (tx_f),
        .timeout_err (tx_timeout_err)
    );

    xrc_rx_seq #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .req         (rx_req_s),
        .ref_lock    (ref_lock_raw),
        .data_lock   (data_lock_raw),
        .flags       (rx_f),
        .timeout_err (rx_timeout_err)
    );

    assign tx_ready      = tx_f.ready;
    assign tx_pll_locked = tx_f.pll_locked;
    assign tx_rst_ack    = tx_f.ack;
    assign rx_ready      = rx_f.ready;
    assign rx_lock_ref   = rx_f.lock_ref;
    assign rx_lock_data  = rx_f.lock_data;
    assign rx_rst_ack    = rx_f.ack;
endmodule

// File: rtl/xrc_checker.sv
module xrc_checker (
    input logic clk,
    input logic rst,
    input logic tx_req_s,
    input logic rx_req_s,
    input logic tx_ready,
    input logic tx_pll_locked,
    input logic tx_rst_ack,
    input logic rx_ready,
    input logic rx_lock_ref,
    input logic rx_lock_data,
    input logic rx_rst_ack,
    input logic tx_timeout_err,
    input logic rx_timeout_err
);
    p_tx_ack_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        tx_rst_ack |-> (!tx_ready && !tx_pll_locked));

    p_tx_ready_first_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_pll_locked) |-> !$past(tx_ready));

    p_tx_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_rst_ack && tx_req_s) |=> tx_rst_ack);

    p_tx_ack_release_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_rst_ack && !tx_req_s) |=> !tx_rst_ack);

    p_tx_ready_needs_pll_r4: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_pll_locked);

    p_tx_pll_before_ready_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_ready) |-> $past(tx_pll_locked));

    p_rx_ack_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rx_rst_ack |-> (!rx_ready && !rx_lock_ref && !rx_lock_data));

    p_rx_ack_after_cdr_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_rst_ack) |-> (!$past(rx_lock_ref) && !$past(rx_ready)));

    p_rx_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_rst_ack && rx_req_s) |=> rx_rst_ack);

    p_rx_ack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_rst_ack && !rx_req_s) |=> !rx_rst_ack);

    p_rx_ready_needs_locks_r7: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> (rx_lock_ref && rx_lock_data));

    p_rx_data_needs_ref_r7: assert property (@(posedge clk) disable iff (rst)
        rx_lock_data |-> rx_lock_ref);

    p_tx_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        tx_timeout_err |=> tx_timeout_err);

    p_rx_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        rx_timeout_err |=> rx_timeout_err);
endmodule

bind xcvr_rst_ctrl xrc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_req_s       (tx_req_s),
    .rx_req_s       (rx_req_s),
    .tx_ready       (tx_ready),
    .tx_pll_locked  (tx_pll_locked),
    .tx_rst_ack     (tx_rst_ack),
    .rx_ready       (rx_ready),
    .rx_lock_ref    (rx_lock_ref),
    .rx_lock_data   (rx_lock_data),
    .rx_rst_ack     (rx_rst_ack),
    .tx_timeout_err (tx_timeout_err),
    .rx_timeout_err (rx_timeout_err)
);

// File: tb/xcvr_rst_ctrl_tb_top.sv
module xcvr_rst_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 24;

    localparam int I_TXR = 0, I_TXP = 1, I_TXA = 2;
    localparam int I_RXR = 3, I_RXF = 4, I_RXD = 5, I_RXA = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_rst_req = 1'b0, rx_rst_req = 1'b0;
    logic pll_lock_raw = 1'b1, ref_lock_raw = 1'b1, data_lock_raw = 1'b1;
    logic tx_ready, tx_pll_locked, tx_rst_ack;
    logic rx_ready, rx_lock_ref, rx_lock_data, rx_rst_ack;
    logic tx_timeout_err, rx_timeout_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int rise_at [7];
    int fall_at [7];
    logic [6:0] prev = '0;
    logic [6:0] obs;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_rst_ctrl #(.LOCK_TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst),
        .tx_rst_req(tx_rst_req), .rx_rst_req(rx_rst_req),
        .pll_lock_raw(pll_lock_raw), .ref_lock_raw(ref_lock_raw),
        .data_lock_raw(data_lock_raw),
        .tx_ready(tx_ready), .tx_pll_locked(tx_pll_locked), .tx_rst_ack(tx_rst_ack),
        .rx_ready(rx_ready), .rx_lock_ref(rx_lock_ref), .rx_lock_data(rx_lock_data),
        .rx_rst_ack(rx_rst_ack),
        .tx_timeout_err(tx_timeout_err), .rx_timeout_err(rx_timeout_err)
    );

    assign obs = {rx_rst_ack, rx_lock_data, rx_lock_ref, rx_ready,
                  tx_rst_ack, tx_pll_locked, tx_ready};

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int i = 0; i < 7; i++) begin
            if (obs[i] && !prev[i]) rise_at[i] = cyc;
            if (!obs[i] && prev[i]) fall_at[i] = cyc;
        end
        prev = obs;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // R12: reset state and start of bring-up
    task automatic t_reset();
        int c;
        rst = 1'b1;
        tick(4);
        chk("R12 outputs low in reset", int'(obs), 0);
        chk("R12 errors low in reset", int'({tx_timeout_err, rx_timeout_err}), 0);
        @(negedge clk); c = cyc; rst = 1'b0;
        tick(6);
        chk("R12 tx pll rise", rise_at[I_TXP], c + 1);
        chk("R4 tx ready after pll", rise_at[I_TXR], c + 2);
        chk("R7 rx ref rise", rise_at[I_RXF], c + 1);
        chk("R7 rx data rise", rise_at[I_RXD], c + 2);
        chk("R7 rx ready last", rise_at[I_RXR], c + 3);
    endtask

    // R1 R2 R3 R4 R8: transmit alone
    task automatic t_tx_cycle();
        int c;
        @(negedge clk); c = cyc; tx_rst_req = 1'b1;
        tick(12);
        chk("R1 tx ready falls after sync", fall_at[I_TXR], c + 3);
        chk("R2 tx pll falls next", fall_at[I_TXP], c + 4);
        chk("R2 tx ack rises last", rise_at[I_TXA], c + 5);
        chk("R3 tx ack held", int'(tx_rst_ack), 1);
        chk("R8 rx untouched by tx", int'({rx_ready, rx_lock_ref, rx_lock_data, rx_rst_ack}), 4'b1110);
        @(negedge clk); c = cyc; tx_rst_req = 1'b0;
        tick(8);
        chk("R3 tx ack falls after release", fall_at[I_TXA], c + 3);
        chk("R4 tx pll rise", rise_at[I_TXP], c + 4);
        chk("R4 tx ready rise", rise_at[I_TXR], c + 5);
    endtask

    // R5 R6 R7 R8: receive alone
    task automatic t_rx_cycle();
        int c;
        @(negedge clk); c = cyc; rx_rst_req = 1'b1;
        tick(12);
        chk("R5 rx ready falls first", fall_at[I_RXR], c + 3);
        chk("R5 rx ref falls", fall_at[I_RXF], c + 4);
        chk("R5 rx data falls with ref", fall_at[I_RXD], c + 4);
        chk("R5 rx ack rises", rise_at[I_RXA], c + 5);
        chk("R6 rx ack held", int'(rx_rst_ack), 1);
        chk("R8 tx untouched by rx", int'({tx_ready, tx_pll_locked, tx_rst_ack}), 3'b110);
        @(negedge clk); c = cyc; rx_rst_req = 1'b0;
        tick(8);
        chk("R6 rx ack falls", fall_at[I_RXA], c + 3);
        chk("R7 rx ref rise", rise_at[I_RXF], c + 4);
        chk("R7 rx data rise", rise_at[I_RXD], c + 5);
        chk("R7 rx ready rise", rise_at[I_RXR], c + 6);
    endtask

    // R8: both together
    task automatic t_both();
        int c;
        @(negedge clk); c = cyc; tx_rst_req = 1'b1; rx_rst_req = 1'b1;
        tick(10);
        chk("R8 tx ack joint", rise_at[I_TXA], c + 5);
        chk("R8 rx ack joint", rise_at[I_RXA], c + 5);
        chk("R8 rx cdr joint", fall_at[I_RXF], c + 4);
        @(negedge clk); c = cyc; tx_rst_req = 1'b0; rx_rst_req = 1'b0;
        tick(8);
        chk("R8 tx ready joint", rise_at[I_TXR], c + 5);
        chk("R8 rx ready joint", rise_at[I_RXR], c + 6);
    endtask

    // R4: PLL lock late after release
    task automatic t_tx_slow_lock();
        int c;
        pll_lock_raw = 1'b0;
        @(negedge clk); tx_rst_req = 1'b1;
        tick(8);
        @(negedge clk); tx_rst_req = 1'b0;
        tick(8);
        chk("R4 no pll status without lock", int'({tx_pll_locked, tx_ready}), 0);
        @(negedge clk); c = cyc; pll_lock_raw = 1'b1;
        tick(4);
        chk("R4 pll follows raw lock", rise_at[I_TXP], c + 1);
        chk("R4 ready follows pll", rise_at[I_TXR], c + 2);
        chk("R10 no timeout when short", int'(tx_timeout_err), 0);
    endtask

    // R9: request released before acknowledge
    task automatic t_early_release();
        int c;
        @(negedge clk); c = cyc; tx_rst_req = 1'b1;
        @(negedge clk); tx_rst_req = 1'b0;
        tick(10);
        chk("R9 full shutdown pll fall", fall_at[I_TXP], c + 4);
        chk("R9 ack rises", rise_at[I_TXA], c + 5);
        chk("R9 ack one cycle", fall_at[I_TXA], c + 6);
        chk("R9 ready returns", rise_at[I_TXR], c + 8);
    endtask

    // R11: data lock loss while running
    task automatic t_data_loss();
        int c;
        @(negedge clk); c = cyc; data_lock_raw = 1'b0;
        tick(5);
        chk("R11 rx ready drops", fall_at[I_RXR], c + 1);
        chk("R11 rx data drops", fall_at[I_RXD], c + 1);
        chk("R11 rx ref kept", int'({rx_lock_ref, rx_rst_ack}), 2'b10);
        @(negedge clk); c = cyc; data_lock_raw = 1'b1;
        tick(4);
        chk("R11 rx data returns", rise_at[I_RXD], c + 1);
        chk("R11 rx ready returns", rise_at[I_RXR], c + 2);
    endtask

    // R10: timeouts
    task automatic t_timeouts();
        pll_lock_raw = 1'b0;
        @(negedge clk); tx_rst_req = 1'b1;
        tick(8);
        @(negedge clk); tx_rst_req = 1'b0;
        tick(TMO / 2);
        chk("R10 tx err not early", int'(tx_timeout_err), 0);
        tick(TMO + 4);
        chk("R10 tx err set", int'(tx_timeout_err), 1);
        chk("R10 tx ready low", int'(tx_ready), 0);
        chk("R10 rx err unaffected", int'(rx_timeout_err), 0);
        pll_lock_raw = 1'b1;
        tick(4);
        chk("R10 tx ready after late lock", int'(tx_ready), 1);
        chk("R10 tx err sticky", int'(tx_timeout_err), 1);
        ref_lock_raw = 1'b0;
        @(negedge clk); rx_rst_req = 1'b1;
        tick(8);
        @(negedge clk); rx_rst_req = 1'b0;
        tick(TMO + 10);
        chk("R10 rx err set", int'(rx_timeout_err), 1);
        chk("R10 rx ready low", int'({rx_ready, rx_lock_ref}), 0);
        ref_lock_raw = 1'b1;
        tick(5);
        chk("R10 rx ready after late lock", int'(rx_ready), 1);
        chk("R10 rx err sticky", int'(rx_timeout_err), 1);
        rst = 1'b1;
        tick(3);
        chk("R12 reset clears errors", int'({tx_timeout_err, rx_timeout_err}), 0);
        rst = 1'b0;
        tick(6);
        chk("R12 back up after reset", int'({tx_ready, rx_ready}), 2'b11);
    endtask

    initial begin
        for (int i = 0; i < 7; i++) begin
            rise_at[i] = -1;
            fall_at[i] = -1;
        end
        t_reset();
        t_tx_cycle();
        t_rx_cycle();
        t_both();
        t_tx_slow_lock();
        t_early_release();
        t_data_loss();
        t_timeouts();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule